// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This engine moves a block of words between one peripheral and system memory while the processor does other work. Software first loads a starting memory address, a word count and a control word through a small register window. Once started, the engine waits for the peripheral to ask for service and then requests the system bus. After the arbiter grants the bus, it drives the memory address and a single read or write strobe for one word. It then acknowledges the peripheral and steps its address and count.

The processor's read and write lines only reach the registers while the grant is low. While the grant is high, the engine owns the memory strobes and the address bus, and `bus_oe` marks the cycles in which it drives them. When the count runs out, the engine gives the bus back, marks the job done and can raise an interrupt.

Top module: `dma_block_mover`

## Requirements
- R1: After a synchronous reset, all registers read as zero and bus_req, bus_oe, mem_rd, mem_wr, dev_ack and irq are 0.
- R2: With bus_grant low, a write with cs and cpu_wr high stores cpu_wdata into the register chosen by reg_sel (0 = address, 1 = word count, 2 = control). A read with cs and cpu_rd high puts that register on cpu_rdata one clock later. The control bits are bit 0 start, bit 1 direction (0 = peripheral to memory, 1 = memory to peripheral), bit 2 interrupt enable and bit 3 done. Any control write clears done.
- R3: While bus_grant is high, register writes from the processor have no effect.
- R4: bus_req rises one clock after a cycle in which start is 1, the word count is nonzero and dev_req is 1, and at no other time from idle.
- R5: bus_oe and the strobes rise only in the clock after bus_grant was sampled high while bus_req was held. mem_addr then equals the address register.
- R6: With direction 0, each word gives one mem_wr cycle carrying the dev_rdata sampled at the grant edge. With direction 1, each word gives one mem_rd cycle, and the mem_rdata of that cycle is presented on dev_wdata.
- R7: dev_ack is a one-clock pulse in the clock after each strobe cycle.
- R8: After each word, the address register is one higher and the word count one lower.
- R9: When the count reaches zero, done is set, start is cleared and bus_req falls one clock later. irq equals done AND interrupt enable, so it falls after a control write.
- R10: If dev_req is low at the acknowledge cycle while words remain, bus_req falls and the transfer resumes once dev_req returns.
- R11: mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Engine select from the address decoder |
| reg_sel | input | 2 | Register select from low address lines |
| cpu_rd | input | 1 | Processor register read |
| cpu_wr | input | 1 | Processor register write |
| cpu_wdata | input | DATA_W | Register write data |
| cpu_rdata | output | DATA_W | Register read data |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant |
| bus_oe | output | 1 | Engine drives address and strobes |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Data written to memory |
| mem_rdata | input | DATA_W | Data read from memory |
| dev_req | input | 1 | Peripheral service request |
| dev_ack | output | 1 | Peripheral acknowledge |
| dev_rdata | input | DATA_W | Word from the peripheral |
| dev_wdata | output | DATA_W | Word to the peripheral |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong sequencer phase shows within one or two clocks as a missing or extra bus_req, strobe or dev_ack edge. A behavioural model follows every clock and compares these outputs, so such an error is caught on the clock where it first appears. A wrong address or count step shows on mem_addr at the next strobe and in the final register read-back. A missed done update shows on irq and on the bus release at the end of the block.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT,
    PH_MOVE,
    PH_ACK
  } phase_t;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int CTRL_START = 0;
  localparam int CTRL_DIR   = 1;
  localparam int CTRL_IE    = 2;
  localparam int CTRL_DONE  = 3;
endpackage

// File: rtl/dma_mover_regs.sv
module dma_mover_regs
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              start,
  output logic              dir,
  output logic              ie,
  output logic              done,
  output logic              irq,
  output logic              cnt_zero
);
  localparam int CTRL_W = 4;

  logic [ADDR_W-1:0] addr_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              start_n, dir_n, ie_n, done_n;
  logic [DATA_W-1:0] rdata_n;
  logic [CTRL_W-1:0] ctrl_view;

  assign cnt_zero  = (cnt == '0);
  assign ctrl_view = {done, ie, dir, start};

  always_comb begin
    addr_n  = addr;
    cnt_n   = cnt;
    start_n = start;
    dir_n   = dir;
    ie_n    = ie;
    done_n  = done;
    if (step) begin
      addr_n = addr + ADDR_W'(1);
      cnt_n  = cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) begin
        done_n  = 1'b1;
        start_n = 1'b0;
      end
    end else if (acc_en && wr_en) begin
      case (reg_sel)
        SEL_ADDR:  addr_n = wdata[ADDR_W-1:0];
        SEL_COUNT: cnt_n  = wdata[CNT_W-1:0];
        SEL_CTRL: begin
          start_n = wdata[CTRL_START];
          dir_n   = wdata[CTRL_DIR];
          ie_n    = wdata[CTRL_IE];
          done_n  = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_ADDR:  rdata_n = DATA_W'(addr);
      SEL_COUNT: rdata_n = DATA_W'(cnt);
      SEL_CTRL:  rdata_n = DATA_W'(ctrl_view);
      default:   rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      cnt   <= '0;
      start <= 1'b0;
      dir   <= 1'b0;
      ie    <= 1'b0;
      done  <= 1'b0;
      irq   <= 1'b0;
      rdata <= '0;
    end else begin
      addr  <= addr_n;
      cnt   <= cnt_n;
      start <= start_n;
      dir   <= dir_n;
      ie    <= ie_n;
      done  <= done_n;
      irq   <= done_n & ie_n;
      if (acc_en && rd_en) rdata <= rdata_n;
    end
  end

  AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    step |=> addr == $past(addr) + ADDR_W'(1)); // R8
  AST_COUNT_RETIRE: assert property (@(posedge clk) disable iff (rst)
    step |=> cnt == $past(cnt) - CNT_W'(1)); // R8
  AST_LAST_WORD_DONE: assert property (@(posedge clk) disable iff (rst)
    (step && cnt == CNT_W'(1)) |=> (done && !start)); // R9
endmodule

// File: rtl/dma_mover_seq.sv
module dma_mover_seq
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir,
  input  logic              cnt_zero,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dev_req,
  input  logic              bus_grant,
  input  logic [DATA_W-1:0] dev_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              step,
  output logic              bus_req,
  output logic              bus_oe,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              dev_ack,
  output logic [DATA_W-1:0] dev_wdata
);
  phase_t phase_q;

  assign step = (phase_q == PH_MOVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      bus_req   <= 1'b0;
      bus_oe    <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      dev_ack   <= 1'b0;
      dev_wdata <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start && !cnt_zero && dev_req) begin
            phase_q <= PH_WAIT;
            bus_req <= 1'b1;
          end
        end
        PH_WAIT: begin
          if (bus_grant) begin
            phase_q   <= PH_MOVE;
            bus_oe    <= 1'b1;
            mem_rd    <= dir;
            mem_wr    <= !dir;
            mem_addr  <= addr;
            mem_wdata <= dev_rdata;
          end
        end
        PH_MOVE: begin
          phase_q   <= PH_ACK;
          bus_oe    <= 1'b0;
          mem_rd    <= 1'b0;
          mem_wr    <= 1'b0;
          dev_ack   <= 1'b1;
          dev_wdata <= mem_rdata;
        end
        PH_ACK: begin
          dev_ack <= 1'b0;
          if (cnt_zero || !dev_req) begin
            phase_q <= PH_IDLE;
            bus_req <= 1'b0;
          end else begin
            phase_q <= PH_WAIT;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_REQ_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(start && !cnt_zero && dev_req)); // R4
  AST_DRIVE_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> $past(bus_grant && bus_req)); // R5
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R11
  AST_STROBE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> bus_oe); // R5
  AST_ACK_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
    bus_oe |=> (dev_ack && !bus_oe)); // R7
endmodule

// File: rtl/dma_block_mover.sv
module dma_block_mover
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic [1:0]        reg_sel,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_req,
  output logic              dev_ack,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              irq
);
  logic              acc_en;
  logic              step;
  logic [ADDR_W-1:0] addr_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              start_w, dir_w, ie_w, done_w, cnt_zero_w;

  // register window is reachable only while the bus belongs to the processor
  assign acc_en = cs && !bus_grant;

  dma_mover_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .acc_en   (acc_en),
    .rd_en    (cpu_rd),
    .wr_en    (cpu_wr),
    .reg_sel  (reg_sel),
    .wdata    (cpu_wdata),
    .step     (step),
    .rdata    (cpu_rdata),
    .addr     (addr_w),
    .cnt      (cnt_w),
    .start    (start_w),
    .dir      (dir_w),
    .ie       (ie_w),
    .done     (done_w),
    .irq      (irq),
    .cnt_zero (cnt_zero_w)
  );

  dma_mover_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start_w),
    .dir       (dir_w),
    .cnt_zero  (cnt_zero_w),
    .addr      (addr_w),
    .dev_req   (dev_req),
    .bus_grant (bus_grant),
    .dev_rdata (dev_rdata),
    .mem_rdata (mem_rdata),
    .step      (step),
    .bus_req   (bus_req),
    .bus_oe    (bus_oe),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .dev_ack   (dev_ack),
    .dev_wdata (dev_wdata)
  );

  AST_GRANTED_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (bus_grant && cs && cpu_wr && !bus_oe) |=> (addr_w == $past(addr_w) && cnt_w == $past(cnt_w))); // R3
  AST_FINISH_RELEASES: assert property (@(posedge clk) disable iff (rst)
    $rose(done_w) |=> !bus_req); // R9
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ie_w); // R9
endmodule

// File: tb/dma_block_mover_test.sv
`timescale 1ns/1ps
module dma_block_mover_test;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, bus_oe, mem_rd, mem_wr, dev_ack, irq;
  logic bus_grant = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_wdata;
  logic dev_req = 1'b0;
  logic [DW-1:0] dev_rdata = '0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem_addr ^ 16'hA5A5;

  dma_block_mover #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .cs(cs), .reg_sel(reg_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_oe(bus_oe), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_req(dev_req), .dev_ack(dev_ack),
    .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .irq(irq)
  );

  // behavioural reference model
  logic [AW-1:0] m_addr;
  logic [CW-1:0] m_cnt;
  logic m_start, m_dir, m_ie, m_done;
  int   m_phase;
  logic e_req, e_oe, e_rd, e_wr, e_ack, e_irq;
  logic [AW-1:0] e_maddr;
  logic [DW-1:0] e_mwdata, e_dwdata, e_rdata;

  always @(posedge clk) begin
    if (rst) begin
      m_addr = '0; m_cnt = '0; m_start = 0; m_dir = 0; m_ie = 0; m_done = 0;
      m_phase = 0; e_req = 0; e_oe = 0; e_rd = 0; e_wr = 0; e_ack = 0; e_irq = 0;
      e_maddr = '0; e_mwdata = '0; e_dwdata = '0; e_rdata = '0;
    end else begin
      if (cs && cpu_rd && !bus_grant) begin
        if (reg_sel == 2'd0) e_rdata = m_addr;
        else if (reg_sel == 2'd1) e_rdata = {8'd0, m_cnt};
        else if (reg_sel == 2'd2) e_rdata = {12'd0, m_done, m_ie, m_dir, m_start};
        else e_rdata = '0;
      end
      if (m_phase == 0) begin
        if (m_start && m_cnt != 0 && dev_req) begin m_phase = 1; e_req = 1; end
      end else if (m_phase == 1) begin
        if (bus_grant) begin
          m_phase = 2; e_oe = 1; e_rd = m_dir; e_wr = !m_dir;
          e_maddr = m_addr; e_mwdata = dev_rdata;
        end
      end else if (m_phase == 2) begin
        m_phase = 3; e_oe = 0; e_rd = 0; e_wr = 0; e_ack = 1;
        e_dwdata = e_maddr ^ 16'hA5A5;
        m_addr = m_addr + 1; m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin m_done = 1; m_start = 0; end
      end else begin
        e_ack = 0;
        if (m_cnt == 0 || !dev_req) begin m_phase = 0; e_req = 0; end
        else m_phase = 1;
      end
      if (cs && cpu_wr && !bus_grant && m_phase != 3 - 0 && 1) begin
        if (reg_sel == 2'd0) m_addr = cpu_wdata;
        else if (reg_sel == 2'd1) m_cnt = cpu_wdata[7:0];
        else if (reg_sel == 2'd2) begin
          m_start = cpu_wdata[0]; m_dir = cpu_wdata[1]; m_ie = cpu_wdata[2]; m_done = 0;
        end
      end
      e_irq = m_done & m_ie;
    end
  end

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit arb_en = 0;
  int rd_seen = 0, wr_seen = 0, ack_seen = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cycles++;
    if (!rst) begin
      check("R4 bus_req", bus_req, e_req);
      check("R5 bus_oe", bus_oe, e_oe);
      check("R5 mem_addr", mem_addr, e_maddr);
      check("R6 mem_rd", mem_rd, e_rd);
      check("R6 mem_wr", mem_wr, e_wr);
      check("R6 mem_wdata", mem_wdata, e_mwdata);
      check("R6 dev_wdata", dev_wdata, e_dwdata);
      check("R7 dev_ack", dev_ack, e_ack);
      check("R9 irq", irq, e_irq);
      check("R2 cpu_rdata", cpu_rdata, e_rdata);
      check("R11 strobes exclusive", mem_rd & mem_wr, 1'b0);
    end
    if (mem_rd) rd_seen++;
    if (mem_wr) wr_seen++;
    if (dev_ack) begin ack_seen++; dev_rdata = dev_rdata + 16'h0011; end
    if (arb_en) bus_grant = bus_req;
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [DW-1:0] d);
    cs = 1; cpu_wr = 1; reg_sel = s; cpu_wdata = d;
    tick();
    cs = 0; cpu_wr = 0;
  endtask

  task automatic read_reg(input logic [1:0] s, input string tag, input logic [DW-1:0] exp);
    cs = 1; cpu_rd = 1; reg_sel = s;
    tick();
    cs = 0; cpu_rd = 0;
    check(tag, cpu_rdata, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R1: reset state
    check("R1 bus_req", bus_req, 0);
    check("R1 irq", irq, 0);
    read_reg(2'd0, "R1 addr after reset", 16'h0000);
    read_reg(2'd2, "R1 ctrl after reset", 16'h0000);

    // R2: program and read back
    write_reg(2'd0, 16'h0100);
    write_reg(2'd1, 16'h0003);
    read_reg(2'd0, "R2 addr readback", 16'h0100);
    read_reg(2'd1, "R2 count readback", 16'h0003);

    // R3: writes ignored under grant
    bus_grant = 1;
    write_reg(2'd0, 16'hFFFF);
    write_reg(2'd2, 16'h0001);
    bus_grant = 0;
    read_reg(2'd0, "R3 addr unchanged", 16'h0100);
    read_reg(2'd2, "R3 ctrl unchanged", 16'h0000);

    // R4: started but no peripheral request
    write_reg(2'd2, 16'h0005);
    repeat (4) tick();
    check("R4 no request without dev_req", bus_req, 0);

    // peripheral to memory, three words, with a pause
    arb_en = 1; dev_rdata = 16'h1000; dev_req = 1;
    wr_seen = 0; ack_seen = 0;
    for (int i = 0; i < 50 && ack_seen == 0; i++) tick();
    dev_req = 0;
    repeat (4) tick();
    check("R10 request dropped while peripheral idle", bus_req, 0);
    dev_req = 1;
    for (int i = 0; i < 100 && !irq; i++) tick();
    check("R9 irq on completion", irq, 1);
    tick();
    check("R9 bus released", bus_req, 0);
    dev_req = 0;
    tick();
    check("R6 write strobes", wr_seen, 3);
    read_reg(2'd0, "R8 final address", 16'h0103);
    read_reg(2'd1, "R8 final count", 16'h0000);
    read_reg(2'd2, "R9 done set start cleared", 16'h000C);
    write_reg(2'd2, 16'h0004);
    check("R9 irq cleared by ctrl write", irq, 0);

    // memory to peripheral, two words, no interrupt
    write_reg(2'd0, 16'h0200);
    write_reg(2'd1, 16'h0002);
    write_reg(2'd2, 16'h0003);
    rd_seen = 0; wr_seen = 0; ack_seen = 0; dev_req = 1;
    for (int i = 0; i < 100 && ack_seen < 2; i++) tick();
    check("R6 last word to peripheral", dev_wdata, 16'h0201 ^ 16'hA5A5);
    dev_req = 0;
    repeat (3) tick();
    check("R6 read strobes", rd_seen, 2);
    check("R6 no write strobes", wr_seen, 0);
    check("R9 irq masked", irq, 0);
    read_reg(2'd2, "R9 done without irq", 16'h000A);

    // R4 boundary: zero count never requests
    write_reg(2'd1, 16'h0000);
    write_reg(2'd2, 16'h0001);
    dev_req = 1;
    repeat (5) tick();
    check("R4 zero count stays idle", bus_req, 0);
    dev_req = 0;
    tick();
    finish_run();
  end
endmodule